// File: doc/BRIEF.md
# Unavailable-Time Alarm and Second Counters

This block watches a stream of one-second results from an upstream performance monitor. Each result is a single-cycle transfer that carries two flags: the second was severely errored (SES), and the second was errored (ES). From this stream the block keeps a real-time unavailable-state alarm. It also drives increment pulses for three saturating counters, which the block holds itself: severely errored seconds, errored seconds and unavailable seconds.

A mode input is sampled while reset is held, and it selects how the counters are fed. In real-time mode, every second is counted as soon as it arrives. In retroactive mode, the counters see each second only ten seconds after it arrived. This delay lets the block date the start and the end of unavailable time to the first second of the run that qualifies the change. Severely errored and errored seconds that fall inside unavailable time are then withheld from their counters.

The input uses valid/ready. `sec_ready` is always high, because the block takes one result per cycle at any rate, so the source never sees back-pressure. A result is consumed on each rising clock edge where `sec_valid` is high. Cycles where `sec_valid` is low are idle.

Top module: `unavail_alarm`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears the alarm, the three pulses and the three counters, and captures `retro_mode`. `retro_mode` has no effect at any other time.
- R2: While the alarm is low, the tenth consecutive accepted second with `sec_ses`=1 raises `alarm` at the edge that accepts it. An accepted second with `sec_ses`=0 restarts that run.
- R3: While the alarm is high, the tenth consecutive accepted second with `sec_ses`=0 lowers `alarm` at the edge that accepts it. An accepted second with `sec_ses`=1 restarts that run.
- R4: In real-time mode (`retro_mode`=0 at reset), the edge that accepts a second sets the pulses for one cycle: `ses_inc`=`sec_ses`, `es_inc`=`sec_es`, and `uas_inc`=the alarm value after that edge.
- R5: Cycles with `sec_valid`=0 change neither the alarm nor the run state, and leave all pulses low. `sec_ready` is always 1.
- R6: In retroactive mode, the pulses for a second are issued at the edge that accepts the tenth later second. The first ten accepted seconds after reset therefore produce no pulse.
- R7: In retroactive mode, a second is unavailable if it lies between two points. The first point is the first second of the ten-SES run that raised the alarm. The second point is the second just before the first second of the ten-clean run that lowered it. For an unavailable second, `uas_inc`=1 and `ses_inc`=`es_inc`=0. For any other second, `ses_inc` and `es_inc` follow its flags.
- R8: In retroactive mode, `alarm` still follows the real-time rule of R2 and R3.
- R9: Each counter stops at 2^CNT_W-1 and never wraps.
- R10: Each counter rises by one at the same edge that sets its pulse, unless it is saturated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| retro_mode | input | 1 | Mode select, sampled only during reset (1 = retroactive) |
| sec_valid | input | 1 | One-second result valid |
| sec_ready | output | 1 | Always 1 |
| sec_ses | input | 1 | Second was severely errored |
| sec_es | input | 1 | Second was errored |
| alarm | output | 1 | Unavailable-state alarm (real time) |
| ses_inc | output | 1 | Severely-errored-second counter increment pulse |
| es_inc | output | 1 | Errored-second counter increment pulse |
| uas_inc | output | 1 | Unavailable-second counter increment pulse |
| ses_count | output | CNT_W | Severely errored seconds |
| es_count | output | CNT_W | Errored seconds |
| uas_count | output | CNT_W | Unavailable seconds |

## Verification
One second-by-second pattern is replayed in both modes. It holds three things:
- A five-SES run cut short by a clean second. This shows that the run restarts rather than accumulates.
- An exact ten-SES onset.
- A recovery run broken by a lone SES, followed by an exact ten-clean recovery.

In real-time mode the pulses must track the input flags directly. In retroactive mode the same pattern must give delayed pulses with withheld error seconds. This separates a design that dates the onset correctly from one that only delays its output. Idle cycles placed between results, and a mode flip after reset, show that neither one disturbs the state. A long all-SES stream drives the counters into saturation.

// File: rtl/unavail_pkg.sv
package unavail_pkg;
  typedef struct packed {
    logic ses;
    logic es;
  } sec_flags_t;
endpackage

// File: rtl/usa_run_detector.sv
module usa_run_detector #(
  parameter int WIN = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic ses,
  output logic unavail_q,
  output logic unavail_d
);
  localparam int RUN_W = $clog2(WIN + 1);

  logic [RUN_W-1:0] run_q;
  logic             qualifies;
  logic             run_done;

  // A second extends the run when it argues for leaving the current state.
  assign qualifies = unavail_q ? ~ses : ses;
  assign run_done  = qualifies && (run_q == RUN_W'(WIN - 1));
  assign unavail_d = (step && run_done) ? ~unavail_q : unavail_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q     <= '0;
      unavail_q <= 1'b0;
    end else if (step) begin
      unavail_q <= unavail_d;
      if (!qualifies || run_done) run_q <= '0;
      else                        run_q <= run_q + RUN_W'(1);
    end
  end

  // R5
  alarm_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(unavail_q) && $stable(run_q));

  // R2
  run_bound_chk: assert property (@(posedge clk) disable iff (rst)
    run_q < RUN_W'(WIN));
endmodule

// File: rtl/usa_history_window.sv
module usa_history_window
  import unavail_pkg::*;
#(
  parameter int DEPTH = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       push,
  input  sec_flags_t din,
  output sec_flags_t oldest,
  output logic       oldest_valid
);
  sec_flags_t       stage_q [DEPTH];
  logic [DEPTH-1:0] vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
    end else if (push) begin
      vld_q      <= {vld_q[DEPTH-2:0], 1'b1};
      stage_q[0] <= din;
      for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign oldest       = stage_q[DEPTH-1];
  assign oldest_valid = vld_q[DEPTH-1];

  // R6
  fill_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !push |=> $stable(vld_q));

  // R6
  fill_order_chk: assert property (@(posedge clk) disable iff (rst)
    oldest_valid |-> (vld_q == '1));
endmodule

// File: rtl/usa_sat_counter.sv
module usa_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst)                    cnt <= '0;
    else if (inc && cnt != TOP) cnt <= cnt + W'(1);
  end

  // R9
  sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cnt == TOP |=> cnt == TOP);

  // R10
  inc_step_chk: assert property (@(posedge clk) disable iff (rst)
    inc && cnt != TOP |=> cnt == $past(cnt) + W'(1));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !inc |=> $stable(cnt));
endmodule

// File: rtl/unavail_alarm.sv
module unavail_alarm
  import unavail_pkg::*;
#(
  parameter int WIN   = 10,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             retro_mode,
  input  logic             sec_valid,
  output logic             sec_ready,
  input  logic             sec_ses,
  input  logic             sec_es,
  output logic             alarm,
  output logic             ses_inc,
  output logic             es_inc,
  output logic             uas_inc,
  output logic [CNT_W-1:0] ses_count,
  output logic [CNT_W-1:0] es_count,
  output logic [CNT_W-1:0] uas_count
);
  localparam int NCNT = 3;

  logic       mode_q;
  logic       step;
  logic       unavail_q, unavail_d;
  sec_flags_t old_flags;
  logic       old_valid;
  logic [NCNT-1:0] inc_d, inc_q;
  logic [CNT_W-1:0] count [NCNT];

  assign sec_ready = 1'b1;
  assign step      = sec_valid;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= retro_mode;
  end

  usa_run_detector #(.WIN(WIN)) u_run (
    .clk(clk), .rst(rst), .step(step), .ses(sec_ses),
    .unavail_q(unavail_q), .unavail_d(unavail_d)
  );

  usa_history_window #(.DEPTH(WIN)) u_hist (
    .clk(clk), .rst(rst), .push(step && mode_q),
    .din('{ses: sec_ses, es: sec_es}),
    .oldest(old_flags), .oldest_valid(old_valid)
  );

  // Index 0: SES, 1: ES, 2: unavailable seconds.
  always_comb begin
    if (mode_q) begin
      // The state before this update is the one that governs the leaving entry.
      inc_d[0] = step && old_valid && old_flags.ses && !unavail_q;
      inc_d[1] = step && old_valid && old_flags.es  && !unavail_q;
      inc_d[2] = step && old_valid && unavail_q;
    end else begin
      inc_d[0] = step && sec_ses;
      inc_d[1] = step && sec_es;
      inc_d[2] = step && unavail_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) inc_q <= '0;
    else     inc_q <= inc_d;
  end

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    usa_sat_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .inc(inc_d[g]), .cnt(count[g])
    );
  end

  assign alarm     = unavail_q;
  assign ses_inc   = inc_q[0];
  assign es_inc    = inc_q[1];
  assign uas_inc   = inc_q[2];
  assign ses_count = count[0];
  assign es_count  = count[1];
  assign uas_count = count[2];

  // R7
  retro_inhibit_chk: assert property (@(posedge clk) disable iff (rst)
    mode_q && uas_inc |-> !ses_inc && !es_inc);

  // R5
  pulse_origin_chk: assert property (@(posedge clk) disable iff (rst)
    (ses_inc || es_inc || uas_inc) |-> $past(sec_valid));

  // R1
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(mode_q));
endmodule

// File: tb/unavail_alarm_tb.sv
module unavail_alarm_tb;
  localparam int CW  = 5;
  localparam int NV  = 36;
  localparam int NS  = 46;
  localparam int TOP = (1 << CW) - 1;

  // {ses, es, expected alarm after that second}
  localparam logic [2:0] VEC [NV] = '{
    3'b110, 3'b110, 3'b110, 3'b110, 3'b110,
    3'b010,
    3'b110, 3'b110, 3'b110, 3'b110, 3'b110, 3'b110, 3'b110, 3'b110, 3'b110,
    3'b111,
    3'b011,
    3'b001, 3'b001, 3'b001, 3'b001,
    3'b111,
    3'b001, 3'b001, 3'b001, 3'b001, 3'b001, 3'b001, 3'b001, 3'b001, 3'b001,
    3'b000, 3'b000, 3'b010, 3'b000, 3'b000
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic retro_mode = 1'b0;
  logic sec_valid = 1'b0;
  logic sec_ses = 1'b0;
  logic sec_es = 1'b0;
  logic sec_ready, alarm, ses_inc, es_inc, uas_inc;
  logic [CW-1:0] ses_count, es_count, uas_count;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  unavail_alarm #(.WIN(10), .CNT_W(CW)) u_dut (
    .clk(clk), .rst(rst), .retro_mode(retro_mode),
    .sec_valid(sec_valid), .sec_ready(sec_ready),
    .sec_ses(sec_ses), .sec_es(sec_es), .alarm(alarm),
    .ses_inc(ses_inc), .es_inc(es_inc), .uas_inc(uas_inc),
    .ses_count(ses_count), .es_count(es_count), .uas_count(uas_count)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst = 1'b1; retro_mode = mode; sec_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    retro_mode = ~mode; // R1: ignored outside reset
    check(alarm == 0, "R1 alarm after reset", alarm, 0);
    check({ses_inc, es_inc, uas_inc} == 0, "R1 pulses after reset", {ses_inc, es_inc, uas_inc}, 0);
    check(ses_count == 0 && es_count == 0 && uas_count == 0, "R1 counters after reset",
          ses_count + es_count + uas_count, 0);
    check(sec_ready == 1, "R5 ready", sec_ready, 1);
  endtask

  // Drive one accepted second; returns with outputs reflecting the accepting edge.
  task automatic send(input logic s, input logic e);
    sec_valid = 1'b1; sec_ses = s; sec_es = e;
    @(posedge clk);
    @(negedge clk);
    sec_valid = 1'b0; sec_ses = ~s; sec_es = ~e;
  endtask

  task automatic run_pattern(input logic mode);
    logic s [NS];
    logic e [NS];
    logic d [NS];
    int xs = 0, xe = 0, xu = 0;
    do_reset(mode);
    for (int k = 0; k < NS; k++) begin
      if (k < NV) {s[k], e[k], d[k]} = VEC[k];
      else        {s[k], e[k], d[k]} = 3'b000;
    end
    for (int k = 0; k < NS; k++) begin
      logic xa, xsi, xei, xui;
      logic a_prev;
      a_prev = alarm;
      send(s[k], e[k]);
      xa = d[k];
      if (!mode) begin
        xsi = s[k]; xei = e[k]; xui = d[k];
      end else if (k >= 10) begin
        // second k-10 is unavailable iff the alarm was set after second k-1
        xui = d[k-1];
        xsi = s[k-10] & ~xui;
        xei = e[k-10] & ~xui;
      end else begin
        xsi = 1'b0; xei = 1'b0; xui = 1'b0;
      end
      xs += xsi; xe += xei; xu += xui;
      if (mode) check(alarm == xa, $sformatf("R8 alarm sec %0d", k), alarm, xa);
      else if (a_prev) check(alarm == xa, $sformatf("R3 alarm sec %0d", k), alarm, xa);
      else check(alarm == xa, $sformatf("R2 alarm sec %0d", k), alarm, xa);
      if (mode) begin
        if (k < 10) check({ses_inc, es_inc, uas_inc} == 0, $sformatf("R6 no pulse sec %0d", k),
                          {ses_inc, es_inc, uas_inc}, 0);
        else check({ses_inc, es_inc, uas_inc} == {xsi, xei, xui},
                   $sformatf("R7 pulses sec %0d", k), {ses_inc, es_inc, uas_inc}, {xsi, xei, xui});
      end else begin
        check({ses_inc, es_inc, uas_inc} == {xsi, xei, xui},
              $sformatf("R4 pulses sec %0d", k), {ses_inc, es_inc, uas_inc}, {xsi, xei, xui});
      end
      check(ses_count == xs && es_count == xe && uas_count == xu,
            $sformatf("R10 counts sec %0d", k), {ses_count, es_count, uas_count}, {xs[4:0], xe[4:0], xu[4:0]});
      if (k % 3 == 0) begin
        // idle cycles in between
        sec_ses = 1'b1; sec_es = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check({ses_inc, es_inc, uas_inc} == 0, "R5 idle pulses", {ses_inc, es_inc, uas_inc}, 0);
        check(alarm == xa, "R5 idle alarm", alarm, xa);
      end
    end
    if (mode) check(ses_count == 5 && es_count == 7 && uas_count == 16, "R7 totals",
                    {ses_count, es_count, uas_count}, {5'd5, 5'd7, 5'd16});
    else check(ses_count == 16 && es_count == 19 && uas_count == 16, "R4 totals",
               {ses_count, es_count, uas_count}, {5'd16, 5'd19, 5'd16});
  endtask

  initial begin
    run_pattern(1'b0);
    run_pattern(1'b1);
    // Saturation: 40 severely errored seconds in real-time mode
    do_reset(1'b0);
    for (int k = 0; k < 40; k++) send(1'b1, 1'b1);
    check(ses_count == TOP, "R9 ses saturate", ses_count, TOP);
    check(es_count == TOP, "R9 es saturate", es_count, TOP);
    check(uas_count == TOP, "R9 uas saturate", uas_count, TOP);
    send(1'b1, 1'b1);
    check(ses_count == TOP && ses_inc == 1, "R9 no wrap", ses_count, TOP);
    // Reset mid-alarm
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check(alarm == 0 && ses_count == 0, "R1 reset clears alarm", alarm, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule